// File: doc/BRIEF.md
# CAN Bus Wake and Off-line Monitor

The block watches one sampled digital level of a CAN bus (1 = dominant, 0 = recessive) and reports two kinds of event. A wake event fires when the bus shows a dominant phase, then a recessive phase, then a second dominant phase, and each of these phases lasts at least a minimum number of clocks. An off-line event fires when the bus holds one level, either one, for the off-line time. The level passes through a two-flop synchronizer before any pattern or timer logic sees it.

The off-line time has a short and a long setting, and a control bit selects between them. A strobe from the mode controller marks Off-line entry. That strobe forces the long setting, whatever the select bit says, until the next wake event. The block also holds the wake flag that the mode controller reads. The Off-line entry strobe clears the flag, and so does the On-line exit strobe, so the flag is ready for the next wake.

Top module: `canwk_monitor`

## Requirements
- R1: A dominant phase, then a recessive phase, then a dominant phase, each at least MIN_PHASE clocks long, gives exactly one `wake_pulse_o` one clock wide. `wake_flag_o` rises on the clock after that pulse. A phase of exactly MIN_PHASE clocks qualifies.
- R2: A phase shorter than MIN_PHASE clocks restarts pattern detection. The phases before it no longer count toward a wake.
- R3: After a wake, the dominant phase that completed it serves as the first phase of the next pattern. One further qualified recessive phase and one further qualified dominant phase give a second wake.
- R4: With `long_sel_i` = 0, the bus input unchanged after a change, and no force active, `offline_pulse_o` rises SHORT_TICKS+3 clocks after the input change. The 3 extra clocks are two synchronizer stages and one register.
- R5: With `long_sel_i` = 1, the same delay uses LONG_TICKS in place of SHORT_TICKS.
- R6: A one-clock `offline_enter_i` strobe makes the timer use LONG_TICKS even with `long_sel_i` = 0. This lasts until the next wake event, after which `long_sel_i` governs again.
- R7: A wake event restarts the off-line timer. With the bus held, the next `offline_pulse_o` comes period+1 clocks after `wake_pulse_o`.
- R8: `wake_flag_o` is 0 on the clock after `offline_enter_i` or `online_exit_i` is high. A clear and a wake on the same clock leave the flag at 0.
- R9: While the bus stays at one level, `offline_pulse_o` repeats every period clocks and is one clock wide.
- R10: During and after reset, all three outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_dom_i | input | 1 | Asynchronous bus level, 1 = dominant |
| long_sel_i | input | 1 | Off-line period select, 1 = LONG_TICKS |
| offline_enter_i | input | 1 | One-clock strobe marking Off-line entry |
| online_exit_i | input | 1 | One-clock strobe marking On-line exit |
| wake_flag_o | output | 1 | Wake flag held for the mode controller |
| wake_pulse_o | output | 1 | One-clock pulse per recognised wake |
| offline_pulse_o | output | 1 | One-clock pulse per off-line timeout |

## Verification
The bench builds the block with MIN_PHASE = 4, SHORT_TICKS = 64 and LONG_TICKS = 256. With these values both timeout lengths, the repeat of a timeout and the forced long setting can each be measured as an exact clock count in a short run. A minimum phase of four clocks makes phases of 3 and 4 clocks the two sides of the filter boundary. Random phases of 1 to 10 clocks land on both sides of that boundary often, and they never reach a timeout, so the wake count can be predicted phase by phase.

// File: rtl/canwk_pkg.sv
package canwk_pkg;
    typedef enum logic [1:0] {
        PAT_IDLE = 2'd0,
        PAT_DOM1 = 2'd1,
        PAT_REC  = 2'd2
    } pat_e;
endpackage

// File: rtl/canwk_sync.sv
module canwk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], d_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/canwk_phase_filter.sv
module canwk_phase_filter
    import canwk_pkg::*;
#(
    parameter int MIN_PHASE = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_i,
    output logic chg_o,
    output logic wake_o
);
    localparam int RUN_W = $clog2(MIN_PHASE + 1);
    localparam logic [RUN_W-1:0] RUN_MIN  = RUN_W'(MIN_PHASE);
    localparam logic [RUN_W-1:0] RUN_LAST = RUN_W'(MIN_PHASE - 1);

    typedef struct packed {
        logic             lvl;
        logic [RUN_W-1:0] run;
        pat_e             pat;
        logic             wake;
    } flt_t;

    flt_t st_d, st_q;
    logic chg, qual;

    always_comb begin
        st_d      = st_q;
        st_d.wake = 1'b0;
        chg       = (lvl_i != st_q.lvl);
        qual      = 1'b0;
        if (chg) begin
            st_d.lvl = lvl_i;
            st_d.run = RUN_W'(1);
            if (st_q.run < RUN_MIN) st_d.pat = PAT_IDLE;
        end else if (st_q.run < RUN_MIN) begin
            st_d.run = st_q.run + RUN_W'(1);
            qual     = (st_q.run == RUN_LAST);
        end
        if (qual) begin
            if (lvl_i) begin
                if (st_q.pat == PAT_REC) st_d.wake = 1'b1;
                st_d.pat = PAT_DOM1;
            end else if (st_q.pat == PAT_DOM1) begin
                st_d.pat = PAT_REC;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{lvl: 1'b0, run: '0, pat: PAT_IDLE, wake: 1'b0};
        else        st_q <= st_d;
    end

    assign chg_o  = chg;
    assign wake_o = st_q.wake;

    AST_WAKE_AFTER_REC: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.wake |-> $past(st_q.pat == PAT_REC));                           // R1
    AST_WAKE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.wake |=> !st_q.wake);                                           // R1
    AST_SHORT_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (chg && st_q.run < RUN_MIN) |=> (st_q.pat == PAT_IDLE));             // R2
endmodule

// File: rtl/canwk_offline_timer.sv
module canwk_offline_timer #(
    parameter int SHORT_TICKS = 1024,
    parameter int LONG_TICKS  = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart_i,
    input  logic wake_i,
    input  logic force_i,
    input  logic long_sel_i,
    output logic pulse_o
);
    localparam int TMR_W = $clog2(LONG_TICKS + 1);
    localparam logic [TMR_W-1:0] LIM_SHORT = TMR_W'(SHORT_TICKS - 1);
    localparam logic [TMR_W-1:0] LIM_LONG  = TMR_W'(LONG_TICKS - 1);

    typedef struct packed {
        logic [TMR_W-1:0] tmr;
        logic             force_long;
        logic             pulse;
    } tmr_t;

    tmr_t st_d, st_q;
    logic [TMR_W-1:0] lim;

    always_comb begin
        st_d       = st_q;
        st_d.pulse = 1'b0;
        if (force_i)     st_d.force_long = 1'b1;
        else if (wake_i) st_d.force_long = 1'b0;
        lim = (force_i || st_q.force_long || long_sel_i) ? LIM_LONG : LIM_SHORT;
        if (restart_i || force_i) begin
            st_d.tmr = '0;
        end else if (st_q.tmr >= lim) begin
            st_d.tmr   = '0;
            st_d.pulse = 1'b1;
        end else begin
            st_d.tmr = st_q.tmr + TMR_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{tmr: '0, force_long: 1'b0, pulse: 1'b0};
        else        st_q <= st_d;
    end

    assign pulse_o = st_q.pulse;

    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.pulse |=> !st_q.pulse);                                         // R9
    AST_TMR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.tmr <= LIM_LONG);                                               // R5
    AST_FORCE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        force_i |=> st_q.force_long);                                        // R6
endmodule

// File: rtl/canwk_monitor.sv
module canwk_monitor #(
    parameter int SYNC_STAGES = 2,
    parameter int MIN_PHASE   = 4,
    parameter int SHORT_TICKS = 1024,
    parameter int LONG_TICKS  = 4096
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_dom_i,
    input  logic long_sel_i,
    input  logic offline_enter_i,
    input  logic online_exit_i,
    output logic wake_flag_o,
    output logic wake_pulse_o,
    output logic offline_pulse_o
);
    logic lvl_s, chg, wake;
    logic flag_d, flag_q, clr;

    canwk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(bus_dom_i), .q_o(lvl_s)
    );

    canwk_phase_filter #(.MIN_PHASE(MIN_PHASE)) u_flt (
        .clk(clk), .rst_n(rst_n), .lvl_i(lvl_s), .chg_o(chg), .wake_o(wake)
    );

    canwk_offline_timer #(.SHORT_TICKS(SHORT_TICKS), .LONG_TICKS(LONG_TICKS)) u_tmr (
        .clk(clk), .rst_n(rst_n), .restart_i(chg | wake), .wake_i(wake),
        .force_i(offline_enter_i), .long_sel_i(long_sel_i), .pulse_o(offline_pulse_o)
    );

    always_comb begin
        clr    = offline_enter_i | online_exit_i;
        flag_d = clr ? 1'b0 : (wake ? 1'b1 : flag_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b0;
        else        flag_q <= flag_d;
    end

    assign wake_flag_o  = flag_q;
    assign wake_pulse_o = wake;

    AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_pulse_o && !offline_enter_i && !online_exit_i) |=> wake_flag_o); // R1
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (offline_enter_i || online_exit_i) |=> !wake_flag_o);                  // R8
endmodule

// File: tb/sim_canwk_monitor.sv
module sim_canwk_monitor;
    localparam int MINP = 4;
    localparam int SHRT = 64;
    localparam int LNG  = 256;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus = 1'b0, sel = 1'b0, ent = 1'b0, ext = 1'b0;
    logic flag, wpul, opul;

    int n_chk = 0, n_fail = 0, wake_cnt = 0, exp_w = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    canwk_monitor #(.SYNC_STAGES(2), .MIN_PHASE(MINP), .SHORT_TICKS(SHRT), .LONG_TICKS(LNG)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_dom_i(bus), .long_sel_i(sel),
        .offline_enter_i(ent), .online_exit_i(ext),
        .wake_flag_o(flag), .wake_pulse_o(wpul), .offline_pulse_o(opul)
    );

    always @(negedge clk) if (wpul) wake_cnt++;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic hold(input logic lvl, input int len);
        bus = lvl;
        repeat (len) @(negedge clk);
    endtask

    task automatic measure_off(input int lim, input string req);
        int n = 0;
        bus = ~bus;
        @(negedge clk); n++;
        while (!opul && n < 5000) begin @(negedge clk); n++; end
        check(n >= lim + 2 && n <= lim + 4, req, n, lim + 3);
    endtask

    task automatic wait_wake(output int n);
        n = 0;
        while (!wpul && n < 100) begin @(negedge clk); n++; end
    endtask

    function automatic int pat_step(int st, bit lvl, int len);
        if (len < MINP) return 0;
        if (lvl) begin
            if (st == 2) exp_w++;
            return 1;
        end
        return (st == 1) ? 2 : st;
    endfunction

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        int n, c0, st;
        bit lv;
        int unsigned sd;
        sd = $urandom(32'd20240611);
        repeat (5) @(negedge clk);
        check(!flag && !wpul && !opul, "R10 reset outputs", {flag, wpul, opul}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!flag && !wpul && !opul, "R10 after reset", {flag, wpul, opul}, 0);

        // R4 short period, then R9 repeat
        measure_off(SHRT, "R4 short timeout");
        n = 0;
        do begin @(negedge clk); n++; end while (!opul && n < 5000);
        check(n >= SHRT - 1 && n <= SHRT + 1, "R9 repeat interval", n, SHRT);

        // R5 long period
        sel = 1'b1;
        hold(1'b0, 2);
        measure_off(LNG, "R5 long timeout");

        // R6 forced long period with select low
        sel = 1'b0;
        ent = 1'b1; @(negedge clk); ent = 1'b0;
        hold(1'b0, 2);
        measure_off(LNG, "R6 forced long");

        // R1 wake, then R7 timer restarted by wake (also clears force: short period)
        c0 = wake_cnt;
        hold(1'b0, 8);
        bus = 1'b1;
        wait_wake(n);
        #1;
        check(wake_cnt - c0 == 1, "R1 wake count", wake_cnt - c0, 1);
        @(negedge clk);
        check(!wpul, "R1 pulse width", wpul, 0);
        check(flag, "R1 flag set", flag, 1);
        n = 1;
        while (!opul && n < 5000) begin @(negedge clk); n++; end
        check(n >= SHRT && n <= SHRT + 2, "R7 restart from wake", n, SHRT + 1);

        // R8 clear by off-line entry
        ent = 1'b1; @(negedge clk); ent = 1'b0;
        @(negedge clk);
        check(!flag, "R8 entry clears", flag, 0);

        // R3 chained wake, with R8 clear winning over set
        c0 = wake_cnt;
        hold(1'b0, 6);
        bus = 1'b1;
        wait_wake(n);
        ext = 1'b1; @(negedge clk); ext = 1'b0;
        #1;
        check(wake_cnt - c0 == 1, "R3 chained wake", wake_cnt - c0, 1);
        @(negedge clk);
        check(!flag, "R8 clear beats set", flag, 0);

        // R8 clear by on-line exit after a set
        hold(1'b0, 6);
        bus = 1'b1;
        wait_wake(n);
        @(negedge clk); @(negedge clk);
        check(flag, "R8 flag before exit", flag, 1);
        ext = 1'b1; @(negedge clk); ext = 1'b0;
        @(negedge clk);
        check(!flag, "R8 exit clears", flag, 0);

        // R2 short phases restart detection
        hold(1'b1, 8);
        c0 = wake_cnt;
        hold(1'b0, 3); hold(1'b1, 8); hold(1'b0, 3); hold(1'b1, 8);
        hold(1'b0, 8); hold(1'b1, 3); hold(1'b0, 8); hold(1'b1, 12);
        #1;
        check(wake_cnt - c0 == 0, "R2 short phase", wake_cnt - c0, 0);

        // R1 boundary: recessive of exactly MIN_PHASE qualifies
        c0 = wake_cnt;
        hold(1'b0, MINP); hold(1'b1, 12);
        #1;
        check(wake_cnt - c0 == 1, "R1 exact minimum phase", wake_cnt - c0, 1);
        check(flag, "R1 flag after boundary wake", flag, 1);

        // Random phases: R1 R2 R3 against a phase-level model
        for (int k = 0; k < 4; k++) begin
            c0 = wake_cnt;
            exp_w = 0;
            st = 1;
            lv = 1'b0;
            for (int i = 0; i < 150; i++) begin
                int len = 1 + int'($urandom % 10);
                hold(lv, len);
                st = pat_step(st, lv, len);
                lv = ~lv;
            end
            if (lv == 1'b0) begin hold(1'b0, 8); st = pat_step(st, 1'b0, 8); lv = 1'b1; end
            hold(1'b1, 20);
            st = pat_step(st, 1'b1, 20);
            repeat (4) @(negedge clk);
            #1;
            check(wake_cnt - c0 == exp_w, "R2 R3 random wake count", wake_cnt - c0, exp_w);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule